// File: doc/BRIEF.md
# Eight-Symbol Parallel Syndrome Generator for a 255-Symbol Reed-Solomon Word

This block is the first stage of a Reed-Solomon decoder for the (255,223) code over GF(2^8). It takes the received word eight symbols per clock and computes the 32 syndromes S1..S32, where Si is the received polynomial evaluated at alpha^i. Each accumulator takes one eight-symbol Horner step per beat. It multiplies its running value by alpha^(8i) and adds the eight new symbols, each weighted by its own fixed power of alpha^i.

The 255-symbol word is sent as 32 beats. A leading zero symbol pads it to 256 positions. The pad sits in the most significant byte lane of the first beat, and the block forces that lane to zero whatever arrives there. When the 32nd beat has been taken, the final syndromes move into an output shift register. From there they leave one per clock, with a valid flag, a last flag, and a flag that marks an all-zero (error-free) set. The accumulators are free again at once, so the next word can arrive with no gap while the previous syndromes are still being emitted.

Top module: `rs8_syndrome`

## Requirements
- R1: While reset is low, and on the first cycles after it is released, `syn_valid`, `syn_last` and `syn_err_free` are low.
- R2: Arithmetic uses the field polynomial x^8+x^4+x^3+x^2+1 (0x11D) with alpha = 0x02. In beat b (0..31), the byte at `in_data[63-8j -: 8]` (lane j, 0..7) is the coefficient of x^(255-8b-j). Syndrome Si (i = 1..32) equals the received polynomial evaluated at alpha^i.
- R3: Lane 0 (`in_data[63:56]`) of the start beat is the pad position and has no effect on any syndrome.
- R4: A valid beat with `in_sop` high always begins a new word, even in the middle of a word. The partial word is abandoned and produces no output.
- R5: Valid beats with `in_sop` low are ignored when no word is open. This covers the time before the first start beat and the time after a word's 32nd beat. Cycles with `in_valid` low leave the accumulation unchanged.
- R6: `syn_valid` goes high on the cycle after the clock edge that takes a word's 32nd beat. It stays high for 32 consecutive cycles, presenting S1 first and S32 last on `syn_data`.
- R7: `syn_last` is high only together with S32, the 32nd cycle of each output run.
- R8: During an output run, `syn_err_free` is high on all 32 cycles when every syndrome of that word is zero, and low on all 32 cycles otherwise.
- R9: Words sent back to back, with no idle beats, each produce a complete and correct run, and the runs follow each other without a gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Beat qualifier for `in_data` |
| in_sop | input | 1 | Marks the first beat of a word |
| in_data | input | 64 | Eight received symbols; lane 0 in the top byte |
| syn_valid | output | 1 | A syndrome is present on `syn_data` |
| syn_last | output | 1 | The current syndrome is S32 |
| syn_data | output | 8 | Syndrome value, S1 first |
| syn_err_free | output | 1 | All 32 syndromes of the current run are zero |

## Verification
A wrong accumulator value, a wrong lane weight or a wrong step constant shows up as a miscompare on `syn_data`. It appears within 32 cycles after the word's last beat, on the syndrome index that the faulty root touches. A wrong beat count or open-word flag shows up sooner, as output runs that start early, start late, or appear with no word behind them. Stray beats are sent to expose this. A bad emit counter shows as a misplaced `syn_last`, a broken run, or a wrong `syn_err_free` level within the same 32-cycle run.

// File: rtl/rs_syn_pkg.sv
package rs_syn_pkg;

    localparam int SYM_W = 8;
    localparam logic [SYM_W:0] FIELD_POLY = 9'h11D;

    typedef logic [SYM_W-1:0] gf_t;

    // Product of two field elements, reduced by the field polynomial.
    function automatic gf_t gf_mul(input gf_t a, input gf_t b);
        gf_t acc;
        gf_t sh;
        acc = '0;
        sh  = a;
        for (int k = 0; k < SYM_W; k++) begin
            if (b[k]) acc = acc ^ sh;
            sh = {sh[SYM_W-2:0], 1'b0} ^ (sh[SYM_W-1] ? FIELD_POLY[SYM_W-1:0] : '0);
        end
        return acc;
    endfunction

    // alpha^e with alpha = 0x02; the exponent is taken modulo 255.
    function automatic gf_t gf_pow(input int e);
        gf_t r;
        int  n;
        r = gf_t'(1);
        n = e % 255;
        for (int k = 0; k < n; k++) r = gf_mul(r, gf_t'(2));
        return r;
    endfunction

endpackage

// File: rtl/rs_syn_cell.sv
// One syndrome root: next accumulator value for an eight-wide Horner step.
module rs_syn_cell
    import rs_syn_pkg::*;
#(
    parameter int ROOT  = 1,
    parameter int LANES = 8
) (
    input  gf_t                      acc_q,
    input  logic [LANES*SYM_W-1:0]   beat,
    input  logic                     restart,
    output gf_t                      acc_d
);

    localparam gf_t STEP = gf_pow(ROOT * LANES);

    gf_t term [LANES];

    generate
        for (genvar j = 0; j < LANES; j++) begin : g_lane
            localparam gf_t WEIGHT = gf_pow(ROOT * (LANES - 1 - j));
            assign term[j] = gf_mul(beat[(LANES-1-j)*SYM_W +: SYM_W], WEIGHT);
        end
    endgenerate

    always_comb begin
        acc_d = restart ? '0 : gf_mul(acc_q, STEP);
        for (int j = 0; j < LANES; j++) acc_d = acc_d ^ term[j];
    end

endmodule

// File: rtl/rs_syn_emit.sv
// Holds a finished syndrome set and shifts it out one value per cycle.
module rs_syn_emit
    import rs_syn_pkg::*;
#(
    parameter int NSYN = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    load,
    input  logic [NSYN*SYM_W-1:0]   load_syn,
    output logic                    out_valid,
    output logic                    out_last,
    output gf_t                     out_data,
    output logic                    out_zero
);

    localparam int IDX_W = $clog2(NSYN);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NSYN - 1);

    typedef struct packed {
        logic                  active;
        logic [IDX_W-1:0]      idx;
        logic                  zero;
        logic [NSYN*SYM_W-1:0] shreg;
    } emit_t;

    emit_t emit_d, emit_q;

    always_comb begin
        emit_d = emit_q;
        if (load) begin
            emit_d.active = 1'b1;
            emit_d.idx    = '0;
            emit_d.zero   = (load_syn == '0);
            emit_d.shreg  = load_syn;
        end else if (emit_q.active) begin
            emit_d.shreg = emit_q.shreg >> SYM_W;
            emit_d.idx   = emit_q.idx + 1'b1;
            if (emit_q.idx == LAST_IDX) emit_d.active = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) emit_q <= '0;
        else        emit_q <= emit_d;
    end

    assign out_valid = emit_q.active;
    assign out_data  = emit_q.shreg[SYM_W-1:0];
    assign out_last  = emit_q.active && (emit_q.idx == LAST_IDX);
    assign out_zero  = emit_q.active && emit_q.zero;

endmodule

// File: rtl/rs8_syndrome.sv
module rs8_syndrome
    import rs_syn_pkg::*;
#(
    parameter int LANES = 8,
    parameter int NSYN  = 32
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   in_valid,
    input  logic                   in_sop,
    input  logic [LANES*8-1:0]     in_data,
    output logic                   syn_valid,
    output logic                   syn_last,
    output logic [7:0]             syn_data,
    output logic                   syn_err_free
);

    localparam int BEATS = 256 / LANES;
    localparam int CNT_W = $clog2(BEATS);
    localparam logic [CNT_W-1:0] LAST_BEAT = CNT_W'(BEATS - 1);

    typedef struct packed {
        logic                        busy;
        logic [CNT_W-1:0]            cnt;
        logic [NSYN-1:0][SYM_W-1:0]  acc;
    } acc_st_t;

    acc_st_t st_d, st_q;

    logic [LANES*SYM_W-1:0]     beat_m;
    logic [NSYN-1:0][SYM_W-1:0] acc_nx;
    logic                       done;

    // The pad symbol in lane 0 of the start beat is forced to zero.
    assign beat_m = in_sop ? {{SYM_W{1'b0}}, in_data[(LANES-1)*SYM_W-1:0]} : in_data;

    generate
        for (genvar i = 0; i < NSYN; i++) begin : g_root
            rs_syn_cell #(
                .ROOT  (i + 1),
                .LANES (LANES)
            ) u_cell (
                .acc_q   (st_q.acc[i]),
                .beat    (beat_m),
                .restart (in_sop),
                .acc_d   (acc_nx[i])
            );
        end
    endgenerate

    always_comb begin
        st_d = st_q;
        done = 1'b0;
        if (in_valid && (in_sop || st_q.busy)) begin
            st_d.acc = acc_nx;
            if (in_sop) begin
                st_d.busy = 1'b1;
                st_d.cnt  = CNT_W'(1);
            end else if (st_q.cnt == LAST_BEAT) begin
                st_d.busy = 1'b0;
                st_d.cnt  = '0;
                done      = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    rs_syn_emit #(
        .NSYN (NSYN)
    ) u_emit (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (done),
        .load_syn  (acc_nx),
        .out_valid (syn_valid),
        .out_last  (syn_last),
        .out_data  (syn_data),
        .out_zero  (syn_err_free)
    );

endmodule

// File: rtl/rs8_syndrome_chk.sv
module rs8_syndrome_chk #(
    parameter int NSYN = 32
) (
    input logic clk,
    input logic rst_n,
    input logic in_valid,
    input logic syn_valid,
    input logic syn_last,
    input logic syn_err_free
);

    localparam int RW = $clog2(NSYN) + 1;

    logic [RW-1:0] run_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                    run_cnt <= '0;
        else if (!syn_valid || syn_last) run_cnt <= '0;
        else                           run_cnt <= run_cnt + 1'b1;
    end

    a_r7_last_only_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
        syn_last |-> syn_valid);

    a_r7_last_at_run_end: assert property (@(posedge clk) disable iff (!rst_n)
        syn_last |-> run_cnt == RW'(NSYN - 1));

    a_r8_free_only_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
        syn_err_free |-> syn_valid);

    a_r8_free_steady_in_run: assert property (@(posedge clk) disable iff (!rst_n)
        (syn_valid && !syn_last) |=> $stable(syn_err_free));

    a_r6_no_gap_in_run: assert property (@(posedge clk) disable iff (!rst_n)
        (syn_valid && !syn_last) |=> syn_valid);

    a_r6_run_follows_beat: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(syn_valid) |-> $past(in_valid));

endmodule

bind rs8_syndrome rs8_syndrome_chk #(.NSYN(NSYN)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_valid     (in_valid),
    .syn_valid    (syn_valid),
    .syn_last     (syn_last),
    .syn_err_free (syn_err_free)
);

// File: tb/tb_rs8_syndrome.sv
module tb_rs8_syndrome;

    localparam int CLK_PERIOD = 10;
    localparam int NV = 8;
    // kinds: 0 zero word, 1 random, 2 shifted generator codeword,
    //        3 codeword plus one error, 4 single unit symbol
    localparam int V_KIND [NV] = '{0, 1, 2, 3, 4, 4, 1, 2};
    localparam int V_ARG  [NV] = '{0, 7, 0, 100, 255, 1, 99, 200};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_sop = 1'b0;
    logic [63:0] in_data = '0;
    logic        syn_valid, syn_last, syn_err_free;
    logic [7:0]  syn_data;

    int n_chk = 0;
    int n_fail = 0;
    int wr_slot = 0;
    int rd_slot = 0;
    int out_idx = 0;
    int out_total = 0;
    int unsigned rs = 32'h1234_5678;
    bit pad_junk = 1'b0;
    bit done_run = 1'b0;

    logic [7:0] word [256];
    logic [7:0] gen [33];
    logic [7:0] exp_syn [32][32];
    bit         exp_zero [32];

    always #(CLK_PERIOD/2) clk = ~clk;

    rs8_syndrome dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sop(in_sop),
        .in_data(in_data), .syn_valid(syn_valid), .syn_last(syn_last),
        .syn_data(syn_data), .syn_err_free(syn_err_free)
    );

    function automatic logic [7:0] fmul(input logic [7:0] a, input logic [7:0] b);
        logic [15:0] p;
        p = '0;
        for (int k = 0; k < 8; k++) if (b[k]) p = p ^ ({8'h00, a} << k);
        for (int k = 15; k >= 8; k--) if (p[k]) p = p ^ (16'h011D << (k - 8));
        return p[7:0];
    endfunction

    function automatic logic [7:0] fpow(input int e);
        logic [7:0] r;
        r = 8'h01;
        for (int k = 0; k < e; k++) r = fmul(r, 8'h02);
        return r;
    endfunction

    function automatic logic [7:0] nb();
        rs = rs * 32'd1664525 + 32'd1013904223;
        return rs[23:16];
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    endtask

    task automatic build_word(input int kind, input int arg);
        for (int k = 0; k < 256; k++) word[k] = 8'h00;
        case (kind)
            1: for (int k = 1; k < 256; k++) word[k] = nb();
            2: for (int d = 0; d <= 32; d++) word[255 - (d + arg)] = gen[d];
            3: begin
                for (int d = 0; d <= 32; d++) word[255 - (d + 5)] = gen[d];
                word[arg] = word[arg] ^ 8'h3C;
            end
            4: word[arg] = 8'h01;
            default: ;
        endcase
    endtask

    // Reference: Si = sum of word[k] * alpha^(i*(255-k)), pad position skipped.
    task automatic post_expected();
        bit allz;
        allz = 1'b1;
        for (int i = 1; i <= 32; i++) begin
            logic [7:0] root, s;
            root = fpow(i);
            s = 8'h00;
            for (int k = 1; k < 256; k++) s = fmul(s, root) ^ word[k];
            exp_syn[wr_slot % 32][i-1] = s;
            if (s != 8'h00) allz = 1'b0;
        end
        exp_zero[wr_slot % 32] = allz;
        wr_slot++;
    endtask

    task automatic send_word(input bit gaps);
        for (int b = 0; b < 32; b++) begin
            if (gaps && (b % 7 == 3)) begin
                @(negedge clk);
                in_valid = 1'b0;
                in_sop   = 1'b0;
                in_data  = {nb(), nb(), nb(), nb(), nb(), nb(), nb(), nb()};
            end
            @(negedge clk);
            in_valid = 1'b1;
            in_sop   = (b == 0);
            for (int j = 0; j < 8; j++) in_data[(7-j)*8 +: 8] = word[8*b + j];
            if (b == 0 && pad_junk) in_data[63:56] = 8'hA5;
        end
    endtask

    task automatic stray_beats(input int n, input bit first_sop);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_sop   = first_sop && (k == 0);
            in_data  = {nb(), nb(), nb(), nb(), nb(), nb(), nb(), nb()};
        end
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            in_valid = 1'b0;
            in_sop   = 1'b0;
        end
    endtask

    // Output monitor: compares each emitted syndrome against the reference.
    always @(negedge clk) begin
        if (rst_n) begin
            if (syn_valid) begin
                out_total++;
                if (rd_slot >= wr_slot) begin
                    chk(1'b0, "R5 output with no word sent", 1, 0);
                end else begin
                    chk(syn_data == exp_syn[rd_slot % 32][out_idx],
                        $sformatf("R2 word %0d S%0d", rd_slot, out_idx + 1),
                        syn_data, exp_syn[rd_slot % 32][out_idx]);
                    chk(syn_last == (out_idx == 31), "R7 last flag",
                        syn_last, out_idx == 31);
                    chk(syn_err_free == exp_zero[rd_slot % 32], "R8 error-free flag",
                        syn_err_free, exp_zero[rd_slot % 32]);
                end
                if (syn_last || out_idx == 31) begin
                    out_idx = 0;
                    rd_slot++;
                end else begin
                    out_idx++;
                end
            end else if (out_idx != 0) begin
                chk(1'b0, "R6 gap inside output run", 0, 1);
                out_idx = 0;
                rd_slot++;
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done_run) begin
            n_fail++;
            $display("FAIL R6 watchdog expired actual=running expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        gen[0] = 8'h01;
        for (int d = 1; d <= 32; d++) gen[d] = 8'h00;
        for (int i = 1; i <= 32; i++) begin
            logic [7:0] root;
            root = fpow(i);
            for (int d = i; d >= 1; d--) gen[d] = gen[d-1] ^ fmul(gen[d], root);
            gen[0] = fmul(gen[0], root);
        end

        // R1: reset state
        repeat (3) @(negedge clk);
        chk(!syn_valid && !syn_last && !syn_err_free, "R1 during reset",
            {syn_valid, syn_last, syn_err_free}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!syn_valid && !syn_last && !syn_err_free, "R1 after release",
            {syn_valid, syn_last, syn_err_free}, 0);

        // R6: output starts the cycle after the last beat is clocked
        build_word(1, 3);
        post_expected();
        send_word(1'b0);
        idle(1);
        chk(syn_valid == 1'b1, "R6 run starts after last beat", syn_valid, 1);
        idle(40);

        // R3: junk in the pad lane of the start beat
        build_word(1, 11);
        post_expected();
        pad_junk = 1'b1;
        send_word(1'b0);
        pad_junk = 1'b0;
        idle(40);

        // R5: stray beats before and after a word, idle gaps inside it
        stray_beats(5, 1'b0);
        build_word(1, 21);
        post_expected();
        send_word(1'b1);
        stray_beats(40, 1'b0);
        idle(40);

        // R4: an abandoned partial word followed by a fresh start
        stray_beats(10, 1'b1);
        build_word(3, 50);
        post_expected();
        send_word(1'b0);
        idle(40);
        chk(rd_slot == wr_slot, "R4 one run per completed word", rd_slot, wr_slot);

        // R9 and R2/R8: vector table sent back to back
        out_total = 0;
        for (int v = 0; v < NV; v++) begin
            build_word(V_KIND[v], V_ARG[v]);
            post_expected();
            send_word(1'b0);
        end
        idle(80);
        chk(rd_slot == wr_slot, "R9 all back-to-back words emitted", rd_slot, wr_slot);
        chk(out_total == NV * 32, "R9 output cycle count", out_total, NV * 32);

        done_run = 1'b1;
        summary();
        $finish;
    end

endmodule